// File: doc/BRIEF.md
# Label Storage Access Engine

This block serves read and write requests aimed at a small byte-wide label memory on behalf of a command mailbox. When a command is launched, the engine pulls its payload one byte at a time from an input stream. It checks the requested window against the configured memory size. It then either streams the requested bytes out or stores the incoming data bytes, one byte per cycle through a synchronous RAM port. Each command closes with a one-cycle result strobe that carries a return code and an output byte count.

Both kinds of payload start with an 8-byte little-endian header. The low word is the byte offset. For a read, the high word is the number of bytes to return. For a write, the high word is reserved and ignored, and the data bytes follow it. The source supplies payload bytes only while the engine asks for them. A rejected command therefore leaves any unconsumed payload bytes in the source.

Top module: `label_store_engine`

## Requirements
- R1: After reset, `busy`, `done`, `in_ready`, `out_valid` and `ram_we` are all low.
- R2: A read takes exactly 8 header bytes, little-endian: offset (bytes 0..3), then length (bytes 4..7). When offset plus length is no more than MEM_BYTES, it emits `length` bytes from ascending addresses starting at the offset, then strobes `done` with code 0x00 and `done_len` equal to the length.
- R3: A read whose offset plus length (computed without wraparound) exceeds MEM_BYTES strobes code 0x02 with `done_len` 0, and emits no byte.
- R4: A write launched with a total length of 0 strobes code 0x00 with `done_len` 0. It draws no payload byte and writes nothing.
- R5: A write with a total length of 1 to 7 strobes code 0x02 with `done_len` 0. It draws no payload byte and writes nothing.
- R6: A write whose offset plus total length exceeds MEM_BYTES + 8 strobes code 0x02 with `done_len` 0. It draws only the 8 header bytes and leaves the memory unchanged.
- R7: An accepted write stores (total length − 8) data bytes at ascending addresses starting at the offset, then strobes code 0x00 with `done_len` 0. The reserved header word has no effect.
- R8: A `start` pulse while the engine is busy is ignored and produces no additional result.
- R9: `done` lasts one cycle. `ram_we` is asserted only together with an accepted input byte. `ram_we` and `out_valid` are never high in the same cycle.
- R10: Windows that end exactly at the top of memory are accepted. This covers a read ending at MEM_BYTES, a zero-length read at offset MEM_BYTES, and a write whose offset plus total length equals MEM_BYTES + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a command (ignored while busy) |
| start_write | input | 1 | 1 = write command, 0 = read command |
| start_len | input | LEN_W | Total write payload length in bytes (unused for reads) |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Engine takes `in_data` this cycle when `in_valid` is high |
| out_valid | output | 1 | Read data byte valid |
| out_data | output | 8 | Read data byte |
| ram_we | output | 1 | Memory write strobe |
| ram_addr | output | AW | Memory byte address |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Memory read data, one cycle after the address |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle result strobe |
| done_code | output | 8 | Return code: 0x00 success, 0x02 invalid input |
| done_len | output | LEN_W | Output byte count for the finished command |

## Verification
Reads are issued at offset zero, inside the memory, ending exactly on its top edge, one byte past it, with zero length, and with an offset so large that a 32-bit sum would wrap. Together these separate a correct inclusive bound from an off-by-one bound and from a truncated comparison. Writes cover zero length, a short length of 1 to 7, an accepted body, a body ending exactly at the top, and one byte over. Each write is followed by read-backs through the ports, so a stray or missing store shows up in the streamed bytes. The bench also counts the payload bytes drawn, which shows whether a rejected write touched its data. A long read is also poked with a second launch to show that the extra launch is ignored.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
   localparam int HDR_BYTES = 8;

   typedef enum logic [7:0] {
      RC_OK        = 8'h00,
      RC_BAD_INPUT = 8'h02
   } rc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_CHK,
      ST_RD,
      ST_WR,
      ST_FIN
   } st_e;
endpackage

// File: rtl/lbl_hdr_shift.sv
module lbl_hdr_shift #(
   parameter int NBYTES = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        take,
   input  logic [7:0]  byte_in,
   output logic [31:0] word_lo,
   output logic [31:0] word_hi,
   output logic        last
);
   localparam int SRW = NBYTES * 8;
   localparam int CW  = $clog2(NBYTES);

   if (NBYTES != 8) begin : g_bad_hdr
      $error("lbl_hdr_shift: header must be 8 bytes");
   end

   logic [SRW-1:0] sr;
   logic [CW-1:0]  cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr  <= '0;
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (take) begin
         sr  <= {byte_in, sr[SRW-1:8]};
         cnt <= cnt + 1'b1;
      end
   end

   assign word_lo = sr[31:0];
   assign word_hi = sr[63:32];
   assign last    = take && (cnt == CW'(NBYTES - 1));
endmodule

// File: rtl/lbl_limit_check.sv
module lbl_limit_check #(
   parameter int MEM_BYTES = 320,
   parameter int LEN_W     = 16,
   parameter int HDR_BYTES = 8
) (
   input  logic             is_write,
   input  logic [31:0]      offset,
   input  logic [31:0]      rd_len,
   input  logic [LEN_W-1:0] wr_len,
   output logic             ok
);
   localparam logic [33:0] RD_LIM = 34'(MEM_BYTES);
   localparam logic [33:0] WR_LIM = 34'(MEM_BYTES + HDR_BYTES);

   logic [33:0] sum_rd;
   logic [33:0] sum_wr;

   always_comb begin
      sum_rd = {2'b00, offset} + {2'b00, rd_len};
      sum_wr = {2'b00, offset} + 34'(wr_len);
      ok     = is_write ? (sum_wr <= WR_LIM) : (sum_rd <= RD_LIM);
   end
endmodule

// File: rtl/lbl_walk_ctr.sv
module lbl_walk_ctr #(
   parameter int AW    = 9,
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    base,
   input  logic [LEN_W-1:0] count,
   input  logic             step,
   output logic [AW-1:0]    addr,
   output logic             empty
);
   logic [AW-1:0]    base_q;
   logic [AW-1:0]    idx;
   logic [LEN_W-1:0] rem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         idx    <= '0;
         rem    <= '0;
      end else if (load) begin
         base_q <= base;
         idx    <= '0;
         rem    <= count;
      end else if (step && rem != '0) begin
         idx <= idx + 1'b1;
         rem <= rem - 1'b1;
      end
   end

   assign addr  = base_q + idx;
   assign empty = (rem == '0);
endmodule

// File: rtl/label_store_engine.sv
module label_store_engine
   import lbl_pkg::*;
#(
   parameter int MEM_BYTES = 320,
   parameter int LEN_W     = 16,
   localparam int AW       = $clog2(MEM_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_write,
   input  logic [LEN_W-1:0] start_len,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             ram_we,
   output logic [AW-1:0]    ram_addr,
   output logic [7:0]       ram_wdata,
   input  logic [7:0]       ram_rdata,
   output logic             busy,
   output logic             done,
   output logic [7:0]       done_code,
   output logic [LEN_W-1:0] done_len
);
   if (MEM_BYTES < 256 || MEM_BYTES > 1024) begin : g_bad_mem
      $error("label_store_engine: MEM_BYTES must lie in 256..1024");
   end
   if (LEN_W <= AW) begin : g_bad_len
      $error("label_store_engine: LEN_W too narrow for MEM_BYTES");
   end

   st_e              state;
   logic             is_wr;
   logic [LEN_W-1:0] cmd_len;
   logic             rd_pend;
   logic [7:0]       code_q;
   logic [LEN_W-1:0] olen_q;

   logic [31:0]      f_off;
   logic [31:0]      f_len;
   logic             hdr_last;
   logic             hdr_take;
   logic             wr_take;
   logic             rd_issue;
   logic             fits;
   logic             walk_load;
   logic [LEN_W-1:0] walk_cnt;
   logic             walk_empty;

   assign hdr_take = (state == ST_HDR) && in_valid;
   assign wr_take  = (state == ST_WR) && !walk_empty && in_valid;
   assign rd_issue = (state == ST_RD) && !walk_empty;
   assign walk_load = (state == ST_CHK) && fits;
   assign walk_cnt  = is_wr ? (cmd_len - LEN_W'(HDR_BYTES)) : f_len[LEN_W-1:0];

   lbl_hdr_shift #(.NBYTES(HDR_BYTES)) u_hdr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state == ST_IDLE),
      .take    (hdr_take),
      .byte_in (in_data),
      .word_lo (f_off),
      .word_hi (f_len),
      .last    (hdr_last)
   );

   lbl_limit_check #(
      .MEM_BYTES (MEM_BYTES),
      .LEN_W     (LEN_W),
      .HDR_BYTES (HDR_BYTES)
   ) u_lim (
      .is_write (is_wr),
      .offset   (f_off),
      .rd_len   (f_len),
      .wr_len   (cmd_len),
      .ok       (fits)
   );

   lbl_walk_ctr #(.AW(AW), .LEN_W(LEN_W)) u_walk (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (walk_load),
      .base  (f_off[AW-1:0]),
      .count (walk_cnt),
      .step  (rd_issue || wr_take),
      .addr  (ram_addr),
      .empty (walk_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_wr   <= 1'b0;
         cmd_len <= '0;
         rd_pend <= 1'b0;
         code_q  <= RC_OK;
         olen_q  <= '0;
      end else begin
         rd_pend <= rd_issue;
         unique case (state)
            ST_IDLE: if (start) begin
               is_wr   <= start_write;
               cmd_len <= start_len;
               olen_q  <= '0;
               if (start_write && start_len == '0) begin
                  code_q <= RC_OK;
                  state  <= ST_FIN;
               end else if (start_write && start_len < LEN_W'(HDR_BYTES)) begin
                  code_q <= RC_BAD_INPUT;
                  state  <= ST_FIN;
               end else begin
                  state <= ST_HDR;
               end
            end
            ST_HDR: if (hdr_last) state <= ST_CHK;
            ST_CHK: begin
               if (fits) begin
                  code_q <= RC_OK;
                  olen_q <= is_wr ? '0 : f_len[LEN_W-1:0];
                  state  <= is_wr ? ST_WR : ST_RD;
               end else begin
                  code_q <= RC_BAD_INPUT;
                  olen_q <= '0;
                  state  <= ST_FIN;
               end
            end
            ST_RD: if (walk_empty) state <= ST_FIN;
            ST_WR: if (walk_empty) state <= ST_FIN;
            ST_FIN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign in_ready  = (state == ST_HDR) || ((state == ST_WR) && !walk_empty);
   assign ram_we    = wr_take;
   assign ram_wdata = in_data;
   assign out_valid = rd_pend;
   assign out_data  = ram_rdata;
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_FIN);
   assign done_code = code_q;
   assign done_len  = olen_q;
endmodule

// File: rtl/lbl_engine_chk.sv
module lbl_engine_chk #(
   parameter int MEM_BYTES = 320,
   parameter int LEN_W     = 16,
   parameter int AW        = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             ram_we,
   input logic [AW-1:0]    ram_addr,
   input logic             busy,
   input logic             done,
   input logic [7:0]       done_code,
   input logic [LEN_W-1:0] done_len
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!in_ready && !ram_we && !out_valid));

   // R3 / R5 / R6: a rejected command reports no output bytes
   assert_reject_zero_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_code != 8'h00) |-> (done_len == '0));

   assert_store_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (32'(ram_addr) < MEM_BYTES));

   assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_we_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (in_valid && in_ready));

   assert_no_mix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && out_valid));
endmodule

bind label_store_engine lbl_engine_chk #(
   .MEM_BYTES (MEM_BYTES),
   .LEN_W     (LEN_W),
   .AW        (AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .busy      (busy),
   .done      (done),
   .done_code (done_code),
   .done_len  (done_len)
);

// File: tb/label_store_engine_test.sv
module label_store_engine_test;
   localparam int MEM   = 320;
   localparam int LEN_W = 16;
   localparam int AW    = $clog2(MEM);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic             start = 1'b0;
   logic             start_write = 1'b0;
   logic [LEN_W-1:0] start_len = '0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = '0;
   logic             in_ready, out_valid, ram_we, busy, done;
   logic [7:0]       out_data, ram_wdata, done_code;
   logic [7:0]       ram_rdata = '0;
   logic [AW-1:0]    ram_addr;
   logic [LEN_W-1:0] done_len;

   label_store_engine #(.MEM_BYTES(MEM), .LEN_W(LEN_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
      .start_len(start_len), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .busy(busy), .done(done),
      .done_code(done_code), .done_len(done_len)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int drawn = 0;
   int done_cnt = 0;
   bit hs = 1'b0;

   logic [7:0] ram [MEM];
   logic [7:0] model [MEM];
   logic [7:0] pq [$];
   logic [7:0] exp_q [$];
   logic [LEN_W+7:0] res_q [$];
   string cur_tag = "";

   // memory model, one cycle read latency
   always @(posedge clk) begin
      if (ram_we && 32'(ram_addr) < MEM) ram[ram_addr] <= ram_wdata;
      if (32'(ram_addr) < MEM) ram_rdata <= ram[ram_addr];
      hs <= in_valid && in_ready;
      cyc <= cyc + 1;
   end

   // payload feeder
   always @(negedge clk) begin
      if (hs && pq.size() > 0) begin
         void'(pq.pop_front());
         drawn = drawn + 1;
      end
      in_valid = (pq.size() > 0);
      in_data  = (pq.size() > 0) ? pq[0] : 8'h00;
   end

   // monitor: compares streamed bytes and results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected out byte %h, expected none", cur_tag, out_data);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (out_data !== e) begin
               errors++;
               $display("FAIL %s: out byte %h, expected %h", cur_tag, out_data, e);
            end
         end
      end
      if (rst_n && done) begin
         done_cnt++;
         checks++;
         if (res_q.size() == 0) begin
            errors++;
            $display("FAIL R8 %s: extra result code %h len %0d, expected none", cur_tag, done_code, done_len);
         end else begin
            logic [LEN_W+7:0] r;
            r = res_q.pop_front();
            if ({done_code, done_len} !== r) begin
               errors++;
               $display("FAIL %s: result code %h len %0d, expected code %h len %0d",
                        cur_tag, done_code, done_len, r[LEN_W+7:LEN_W], r[LEN_W-1:0]);
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: cycle %0d, expected end before 150000", cyc);
         finish_run();
      end
   end

   task automatic check(input string tag, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
      end
   endtask

   task automatic hdr(ref logic [7:0] q[$], input logic [31:0] a, input logic [31:0] b);
      q.delete();
      for (int i = 0; i < 4; i++) q.push_back(a[8*i +: 8]);
      for (int i = 0; i < 4; i++) q.push_back(b[8*i +: 8]);
   endtask

   // driver: computes expectations from the requirements, then launches
   task automatic run(input string tag, input bit wr, input int len,
                      input logic [7:0] pl[$], input bit poke);
      longint off, f2;
      int exp_code, exp_len, exp_drawn, base_cnt;
      off = 0; f2 = 0;
      for (int i = 0; i < 4 && i < pl.size(); i++) off = off | (longint'(pl[i]) << (8*i));
      for (int i = 4; i < 8 && i < pl.size(); i++) f2 = f2 | (longint'(pl[i]) << (8*(i-4)));
      if (!wr) begin
         exp_drawn = 8;
         if (off + f2 > MEM) begin exp_code = 2; exp_len = 0; end
         else begin
            exp_code = 0; exp_len = int'(f2);
            for (int i = 0; i < f2; i++) exp_q.push_back(model[int'(off) + i]);
         end
      end else if (len == 0) begin exp_code = 0; exp_len = 0; exp_drawn = 0; end
      else if (len < 8) begin exp_code = 2; exp_len = 0; exp_drawn = 0; end
      else if (off + len > MEM + 8) begin exp_code = 2; exp_len = 0; exp_drawn = 8; end
      else begin
         exp_code = 0; exp_len = 0; exp_drawn = len;
         for (int i = 8; i < len; i++) model[int'(off) + i - 8] = pl[i];
      end
      @(negedge clk); #1;
      cur_tag = tag;
      drawn = 0;
      base_cnt = done_cnt;
      res_q.push_back({8'(exp_code), LEN_W'(exp_len)});
      foreach (pl[i]) pq.push_back(pl[i]);
      start = 1'b1; start_write = wr; start_len = LEN_W'(len);
      @(negedge clk); #1;
      start = 1'b0;
      if (poke) begin
         repeat (12) @(negedge clk);
         #1;
         start = 1'b1; start_write = 1'b1; start_len = '0;
         @(negedge clk); #1;
         start = 1'b0;
      end
      while (done_cnt == base_cnt) begin
         @(negedge clk); #1;
      end
      repeat (4) @(negedge clk);
      #1;
      check({tag, " bytes drawn"}, drawn, exp_drawn);
      check({tag, " out bytes pending"}, exp_q.size(), 0);
      check({tag, " results seen"}, done_cnt - base_cnt, 1);
      pq.delete();
      exp_q.delete();
   endtask

   task automatic rd(input string tag, input int a, input int b, input bit poke);
      logic [7:0] q[$];
      hdr(q, 32'(a), 32'(b));
      run(tag, 1'b0, 8, q, poke);
   endtask

   task automatic wrc(input string tag, input int a, input int total, input int seed);
      logic [7:0] q[$];
      hdr(q, 32'(a), 32'hDEAD_BEEF);
      for (int i = 8; i < total; i++) q.push_back(8'(seed + 7 * i));
      run(tag, 1'b1, total, q, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < MEM; i++) begin
         ram[i]   = 8'(i * 3 + 1);
         model[i] = 8'(i * 3 + 1);
      end
      repeat (3) @(negedge clk);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 in_ready", in_ready, 0);
      check("R1 out_valid", out_valid, 0);
      check("R1 ram_we", ram_we, 0);
      #1 rst_n = 1'b1;

      rd("R2 read base", 0, 16, 1'b0);
      rd("R2 read middle", 77, 5, 1'b0);
      rd("R10 read to top", 300, 20, 1'b0);
      rd("R3 read past top", 301, 20, 1'b0);
      rd("R10 zero read at top", MEM, 0, 1'b0);
      rd("R3 read wrapping offset", 32'hFFFF_FFF0, 32'h20, 1'b0);

      wrc("R4 write empty", 40, 0, 0);
      rd("R4 readback", 32, 16, 1'b0);
      wrc("R5 write short", 40, 5, 0);
      rd("R5 readback", 32, 16, 1'b0);
      wrc("R7 write body", 100, 20, 9);
      rd("R7 readback", 96, 20, 1'b0);
      wrc("R10 write to top", 310, 18, 55);
      rd("R10 write readback", 300, 20, 1'b0);
      wrc("R6 write past top", 311, 18, 99);
      rd("R6 readback", 300, 20, 1'b0);
      wrc("R7 header only", 200, 8, 0);
      rd("R7 header only readback", 198, 6, 1'b0);

      rd("R8 start while busy", 10, 64, 1'b1);
      rd("R9 final read", 0, 40, 1'b0);

      finish_run();
   end
endmodule